// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block maps the small address windows that a game console's CPU and video bus can reach onto larger program and character ROMs. The CPU reaches it through two write ports. A write to the select port stores a register index and two mode bits. A write to the data port then loads the byte into the bank register named by that index. Eight bank registers hold bank numbers. Six of them serve character memory and two serve program memory, and they store different numbers of bits.

The high address lines of both ROMs come straight from multiplexers. Each character output bit has its own 8-to-1 multiplexer, selected by video-bus address bits A12..A10 (A12 can be inverted by a mode bit). Each program output bit has its own 4-to-1 multiplexer, selected by CPU address bits A14..A13. Both output widths are parameters, so a smaller build can drop the highest ROM lines. Each dropped line removes its multiplexer and the storage that fed it.

Top module: `bank_mapper`

## Requirements
- R1: After reset the select register and all eight bank registers are zero. With vid_hi = v, chr_hi is then 0 except bit 0, which equals v[0] whenever v[2] is 0. prg_hi is 0 for CPU windows 0 and 1, 0x3E for window 2 and 0x3F for window 3 (the window is cpu_addr[14:13]).
- R2: A write counts only when cpu_wr is high, cpu_addr[15] is 1 and cpu_addr[14:13] is 00. cpu_addr[0]=0 selects the select port and cpu_addr[0]=1 selects the data port. Any other write leaves every output unchanged.
- R3: A select-port write stores cpu_data[2:0] as the register index, cpu_data[6] as the program-mode bit and cpu_data[7] as the character-inversion bit.
- R4: A data-port write loads the register named by the index. Registers 0 and 1 keep cpu_data[7:1]. Registers 2 to 5 keep cpu_data[7:0]. Registers 6 and 7 keep cpu_data[5:0].
- R5: With inversion off and vid_hi[2]=0, chr_hi is {register (vid_hi[1] ? 1 : 0) bits 7:1, vid_hi[0]}. With vid_hi[2]=1, chr_hi is register 2+vid_hi[1:0].
- R6: With the inversion bit set, the character mapping of R5 uses !vid_hi[2] in place of vid_hi[2].
- R7: In program mode 0, windows 0, 1, 2 and 3 map to register 6, register 7, bank 0x3E and bank 0x3F.
- R8: In program mode 1, window 0 maps to bank 0x3E and window 2 maps to register 6. Windows 1 and 3 are as in R7.
- R9: The outputs follow vid_hi and cpu_addr with no clock delay. A register write changes the outputs only after the rising edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| vid_hi | input | 3 | Video-bus address bits A12..A10 |
| chr_hi | output | CHR_W (8) | Character ROM address bits A10 upward |
| prg_hi | output | PRG_W (6) | Program ROM address bits A13 upward |

## Verification
Both ROM outputs are combinational, so they are due within the same cycle as a change of vid_hi or cpu_addr. The bench therefore samples them 1 ns after setting the addresses, away from any clock edge. A register write is due one edge after the strobe. The bench raises the strobe at a falling edge, checks the outputs at once for the old value, and checks them again at the next falling edge for the new value. After every write the bench sweeps all eight video selects and all four CPU windows against its model.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    localparam int MAP_DATA_W    = 8;
    localparam int MAP_IDX_W     = 3;
    localparam int MAP_MODE_BIT  = 6;
    localparam int MAP_INV_BIT   = 7;
    localparam int CHR_2K_REGS   = 2;
    localparam int CHR_1K_REGS   = 4;
    localparam int PRG_REGS      = 2;

    typedef struct packed {
        logic                 chr_inv;
        logic                 prg_mode;
        logic [MAP_IDX_W-1:0] idx;
    } map_ctrl_t;
endpackage

// File: rtl/bm_port_decode.sv
module bm_port_decode
    import bank_mapper_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [MAP_DATA_W-1:0] cpu_data,
    input  logic                  cpu_wr,
    output map_ctrl_t             ctrl_o,
    output logic                  data_wr_o
);
    typedef struct packed {
        map_ctrl_t ctrl;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       hit, sel_wr;

    always_comb begin
        hit       = cpu_wr && cpu_addr[ADDR_W-1] && (cpu_addr[ADDR_W-2:ADDR_W-3] == 2'b00);
        sel_wr    = hit && !cpu_addr[0];
        data_wr_o = hit && cpu_addr[0];
        st_d      = st_q;
        if (sel_wr) begin
            st_d.ctrl.idx      = cpu_data[MAP_IDX_W-1:0];
            st_d.ctrl.prg_mode = cpu_data[MAP_MODE_BIT];
            st_d.ctrl.chr_inv  = cpu_data[MAP_INV_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;

    // R3: select-port write lands in the control fields one edge later
    a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2:ADDR_W-3] == 2'b00 && !cpu_addr[0])
        |=> (ctrl_o == {$past(cpu_data[MAP_INV_BIT]), $past(cpu_data[MAP_MODE_BIT]),
                        $past(cpu_data[MAP_IDX_W-1:0])}));

    // R2: writes outside the decoded range leave the control register alone
    a_r2_ignore_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !(cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2:ADDR_W-3] == 2'b00))
        |=> $stable(ctrl_o));
endmodule

// File: rtl/bm_bank_file.sv
module bm_bank_file
    import bank_mapper_pkg::*;
#(
    parameter int CHR_W = 8,
    parameter int PRG_W = 6,
    localparam int C2W  = CHR_W - 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                data_wr,
    input  logic [MAP_IDX_W-1:0]                idx,
    input  logic [MAP_DATA_W-1:0]               data,
    output logic [CHR_2K_REGS-1:0][C2W-1:0]     c2k_o,
    output logic [CHR_1K_REGS-1:0][CHR_W-1:0]   c1k_o,
    output logic [PRG_REGS-1:0][PRG_W-1:0]      prg_o
);
    localparam int C1K_BASE = CHR_2K_REGS;
    localparam int PRG_BASE = CHR_2K_REGS + CHR_1K_REGS;

    typedef struct packed {
        logic [CHR_2K_REGS-1:0][C2W-1:0]   c2k;
        logic [CHR_1K_REGS-1:0][CHR_W-1:0] c1k;
        logic [PRG_REGS-1:0][PRG_W-1:0]    prg;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (data_wr) begin
            for (int i = 0; i < CHR_2K_REGS; i++)
                if (idx == MAP_IDX_W'(i)) bank_d.c2k[i] = data[CHR_W-1:1];
            for (int i = 0; i < CHR_1K_REGS; i++)
                if (idx == MAP_IDX_W'(C1K_BASE + i)) bank_d.c1k[i] = data[CHR_W-1:0];
            for (int i = 0; i < PRG_REGS; i++)
                if (idx == MAP_IDX_W'(PRG_BASE + i)) bank_d.prg[i] = data[PRG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign c2k_o = bank_q.c2k;
    assign c1k_o = bank_q.c1k;
    assign prg_o = bank_q.prg;

    // R4: program registers keep only the low PRG_W data bits
    a_r4_prg_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == MAP_IDX_W'(PRG_BASE)) |=> (prg_o[0] == $past(data[PRG_W-1:0])));

    // R4: 2 KB registers drop data bit 0
    a_r4_c2k_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == '0) |=> (c2k_o[0] == $past(data[CHR_W-1:1])));

    // R2: without a data-port write no bank register moves
    a_r2_hold_banks: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> ($stable(c2k_o) && $stable(c1k_o) && $stable(prg_o)));
endmodule

// File: rtl/bm_chr_mux.sv
module bm_chr_mux
    import bank_mapper_pkg::*;
#(
    parameter int CHR_W = 8,
    localparam int C2W  = CHR_W - 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CHR_2K_REGS-1:0][C2W-1:0]   c2k,
    input  logic [CHR_1K_REGS-1:0][CHR_W-1:0] c1k,
    input  logic [2:0]                        vid_hi,
    input  logic                              inv,
    output logic [CHR_W-1:0]                  chr_o
);
    logic [2:0] sel;
    assign sel = {vid_hi[2] ^ inv, vid_hi[1:0]};

    for (genvar k = 0; k < CHR_W; k++) begin : g_bit
        logic [7:0] cand;
        if (k == 0) begin : g_low
            assign cand = {c1k[3][0], c1k[2][0], c1k[1][0], c1k[0][0],
                           1'b1, 1'b0, 1'b1, 1'b0};
        end else begin : g_high
            assign cand = {c1k[3][k], c1k[2][k], c1k[1][k], c1k[0][k],
                           c2k[1][k-1], c2k[1][k-1], c2k[0][k-1], c2k[0][k-1]};
        end
        assign chr_o[k] = cand[sel];
    end

    // R5/R6: in a 2 KB region the lowest output bit is video A10
    a_r5_a10_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((vid_hi[2] ^ inv) == 1'b0) |-> (chr_o[0] == vid_hi[0]));

    // R6: flipping inversion and A12 together gives the same bank
    a_r6_inv_sym: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(c2k) && $stable(c1k) && $stable(vid_hi[1:0]) &&
         (vid_hi[2] ^ inv) == $past(vid_hi[2] ^ inv)) |-> $stable(chr_o));
endmodule

// File: rtl/bm_prg_mux.sv
module bm_prg_mux
    import bank_mapper_pkg::*;
#(
    parameter int PRG_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PRG_REGS-1:0][PRG_W-1:0] prg,
    input  logic                           mode,
    input  logic [1:0]                     win,
    output logic [PRG_W-1:0]               prg_o
);
    for (genvar k = 0; k < PRG_W; k++) begin : g_bit
        logic [3:0] cand;
        logic       penult;
        assign penult = (k == 0) ? 1'b0 : 1'b1;
        assign cand = {1'b1,
                       mode ? prg[0][k] : penult,
                       prg[1][k],
                       mode ? penult : prg[0][k]};
        assign prg_o[k] = cand[win];
    end

    // R7: the top window is always the last bank
    a_r7_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (win == 2'd3) |-> (&prg_o));

    // R8: in mode 1 the lowest window is the second-to-last bank
    a_r8_swap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && win == 2'd0) |-> (prg_o == {{(PRG_W-1){1'b1}}, 1'b0}));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int CHR_W  = 8,
    parameter int PRG_W  = 6,
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [MAP_DATA_W-1:0] cpu_data,
    input  logic                  cpu_wr,
    input  logic [2:0]            vid_hi,
    output logic [CHR_W-1:0]      chr_hi,
    output logic [PRG_W-1:0]      prg_hi
);
    localparam int C2W = CHR_W - 1;

    map_ctrl_t                         ctrl;
    logic                              data_wr;
    logic [CHR_2K_REGS-1:0][C2W-1:0]   c2k;
    logic [CHR_1K_REGS-1:0][CHR_W-1:0] c1k;
    logic [PRG_REGS-1:0][PRG_W-1:0]    prg;

    bm_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ctrl_o(ctrl), .data_wr_o(data_wr)
    );

    bm_bank_file #(.CHR_W(CHR_W), .PRG_W(PRG_W)) u_banks (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(ctrl.idx),
        .data(cpu_data), .c2k_o(c2k), .c1k_o(c1k), .prg_o(prg)
    );

    bm_chr_mux #(.CHR_W(CHR_W)) u_chr (
        .clk(clk), .rst_n(rst_n), .c2k(c2k), .c1k(c1k), .vid_hi(vid_hi),
        .inv(ctrl.chr_inv), .chr_o(chr_hi)
    );

    bm_prg_mux #(.PRG_W(PRG_W)) u_prg (
        .clk(clk), .rst_n(rst_n), .prg(prg), .mode(ctrl.prg_mode),
        .win(cpu_addr[ADDR_W-2:ADDR_W-3]), .prg_o(prg_hi)
    );
endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [2:0]  vid_hi = 3'd0;
    logic [7:0]  chr_hi;
    logic [5:0]  prg_hi;

    int n_run = 0, n_fail = 0;
    logic [7:0] m_reg [8];
    logic [2:0] m_idx;
    logic       m_mode, m_inv;

    bank_mapper dut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
                     .cpu_wr(cpu_wr), .vid_hi(vid_hi), .chr_hi(chr_hi), .prg_hi(prg_hi));

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_chr(input logic [2:0] v);
        logic [7:0] r;
        if ((v[2] ^ m_inv) == 1'b0) begin
            r = v[1] ? m_reg[1] : m_reg[0];
            return {r[7:1], v[0]};
        end
        return m_reg[2 + v[1:0]];
    endfunction

    function automatic logic [5:0] exp_prg(input logic [1:0] w);
        case (w)
            2'd0: return m_mode ? 6'h3E : m_reg[6][5:0];
            2'd1: return m_reg[7][5:0];
            2'd2: return m_mode ? m_reg[6][5:0] : 6'h3E;
            default: return 6'h3F;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_idx = 3'd0; m_mode = 1'b0; m_inv = 1'b0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15] && a[14:13] == 2'b00) begin
            if (!a[0]) begin
                m_idx = d[2:0]; m_mode = d[6]; m_inv = d[7];
            end else begin
                case (m_idx)
                    3'd0, 3'd1: m_reg[m_idx] = d & 8'hFE;
                    3'd6, 3'd7: m_reg[m_idx] = d & 8'h3F;
                    default:    m_reg[m_idx] = d;
                endcase
            end
        end
    endtask

    task automatic check_all(input string req);
        cpu_wr = 1'b0;
        for (int v = 0; v < 8; v++) begin
            vid_hi = 3'(v);
            #1;
            n_run++;
            if (chr_hi !== exp_chr(3'(v))) begin
                n_fail++;
                $display("FAIL %s chr vid=%0d got %h exp %h", req, v, chr_hi, exp_chr(3'(v)));
            end
        end
        for (int w = 0; w < 4; w++) begin
            cpu_addr = {1'b1, 2'(w), 13'h0ABC};
            #1;
            n_run++;
            if (prg_hi !== exp_prg(2'(w))) begin
                n_fail++;
                $display("FAIL %s prg win=%0d got %h exp %h", req, w, prg_hi, exp_prg(2'(w)));
            end
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pick [10];
        void'($urandom(32'd1234));
        pick = '{16'h8000, 16'h8001, 16'h9FFE, 16'h9FFF, 16'hA000,
                 16'hC001, 16'hE000, 16'h0001, 16'h7FFF, 16'hA001};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: writes outside the decoded range
        cpu_write(16'hA000, 8'h06);
        cpu_write(16'hC001, 8'hFF);
        cpu_write(16'h0001, 8'hFF);
        check_all("R2");

        // R3/R4: load every register, including truncation
        for (int i = 0; i < 8; i++) begin
            cpu_write(16'h8000, 8'(i));
            cpu_write(16'h8001, 8'hFF - 8'(i * 17));
        end
        check_all("R4");
        check_all("R5");

        // R9: new data is not visible before the sampling edge
        cpu_write(16'h8000, 8'h02);
        vid_hi = 3'd4;
        @(negedge clk);
        cpu_addr = 16'h8001; cpu_data = 8'h5A; cpu_wr = 1'b1;
        #1;
        n_run++;
        if (chr_hi !== exp_chr(3'd4)) begin
            n_fail++;
            $display("FAIL R9 early got %h exp %h", chr_hi, exp_chr(3'd4));
        end
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(16'h8001, 8'h5A);
        n_run++;
        if (chr_hi !== 8'h5A) begin
            n_fail++;
            $display("FAIL R9 late got %h exp %h", chr_hi, 8'h5A);
        end

        // R6, R8: inversion and program mode
        cpu_write(16'h8000, 8'h80);
        check_all("R6");
        cpu_write(16'h8000, 8'h46);
        check_all("R8");
        cpu_write(16'h9FFE, 8'h07);
        check_all("R7");
        cpu_write(16'h8000, 8'h80);
        check_all("R3");

        // random mix of decoded and stray writes
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            a = ($urandom % 4 == 0) ? 16'($urandom) : pick[$urandom % 10];
            cpu_write(a, 8'($urandom));
            if (n % 8 == 7) check_all("R2/R5/R7 random");
        end

        // R1: reset returns to the cleared state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R1 again");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule